// File: doc/BRIEF.md
# Direct-Mapped Instruction Cache with Quad-Word Line Refill

This block sits between a processor core's instruction fetch stage and an external memory read port. Each fetch supplies a physical word address. The cache splits that address into a word offset, a line index and a tag. A hit returns the stored word one cycle after the request is accepted. A miss stalls the core and issues one read of the whole 16-byte line, which holds four 32-bit words. The four returning words are collected in a four-entry staging buffer, one entry per word. Memory may deliver them on consecutive clocks or with any number of idle clocks between them. Only when all four have arrived is the line copied from the buffer into the data array, one word per clock, and marked valid. The stalled fetch is then completed with the word it asked for.

Capacity is set by the parameter `CACHE_BYTES`, which is 4096 or 8192. The line count, the index width and the tag width follow from it. Tags are physical, so any address in the 4 GB space can be cached and no flush is needed on a context switch. An invalidate-all input walks an index counter once over every line and clears its valid bit. If this input arrives while a refill is in progress, the clearing waits until that refill has completed.

Controller states and transitions:
- IDLE: accepts fetches. A hit stays in IDLE. A miss goes to COLLECT. An invalidate request, whether new or pending, goes to SWEEP.
- COLLECT: waits for the staging buffer to hold four words, then goes to FILL.
- FILL: copies buffer entries 0 to 3 into the data array over four cycles, then goes to ANSWER.
- ANSWER: returns the critical word, empties the buffer and goes to IDLE.
- SWEEP: clears one valid bit per cycle and returns to IDLE after the last line.

Top module: `icache_qw`

## Requirements
- R1: After reset, `fetch_ready` is 1, `rsp_valid` is 0, `mem_rd_req` is 0, and every line is invalid, so the first fetch misses.
- R2: A fetch accepted in a cycle where `fetch_req` and `fetch_ready` are both 1, and whose line is present, raises `rsp_valid` for one cycle on the next clock. It carries the stored word and issues no memory read.
- R3: A fetch that misses raises `mem_rd_req` for exactly one cycle, on the clock after acceptance. `mem_rd_addr` then holds the byte address of the line with bits [3:0] equal to zero.
- R4: The staging buffer takes the refill words in arrival order as line words 0, 1, 2 and 3 (byte offsets 0, 4, 8 and 12). These may arrive on back-to-back clocks or spaced apart. A `mem_word_valid` strobe that arrives after the fourth word, or while no refill is pending, has no effect on cached contents.
- R5: `fetch_ready` stays 0 from the accepted miss until its response. No response appears before the fourth word has arrived.
- R6: After the fill, the stalled fetch receives one `rsp_valid` pulse carrying the word at its own offset within the line.
- R7: The line index is word-address bits [IDX_W+1:2], with IDX_W = log2(CACHE_BYTES/16), and the tag is the bits above it. Two addresses with the same index but different tags replace each other. Lines at different indices coexist.
- R8: A one-cycle `inv_all` pulse while idle holds `fetch_ready` at 0 for exactly CACHE_BYTES/16 cycles after the accepting clock. No request is accepted during that time, and afterwards every line misses.
- R9: An `inv_all` pulse during a refill does not disturb that refill or its response. The sweep starts after that refill ends: `fetch_ready` is 0 for CACHE_BYTES/16 + 1 cycles after the response, and the line just filled then misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_req | input | 1 | Fetch request |
| fetch_waddr | input | 30 | Physical word address of the fetch |
| fetch_ready | output | 1 | Cache can accept a fetch this cycle |
| rsp_valid | output | 1 | One-cycle fetch response strobe |
| rsp_data | output | 32 | Instruction word returned |
| inv_all | input | 1 | Invalidate every line |
| mem_rd_req | output | 1 | One-cycle quad-word read request |
| mem_rd_addr | output | 32 | Line-aligned byte address of the read |
| mem_word_valid | input | 1 | A refill word is on `mem_word_data` |
| mem_word_data | input | 32 | Refill word |

## Verification
A vector table runs a sequence of fetches. It covers cold misses, hits at every word offset, and a pair of lines that share an index and so replace each other. It also includes the last line of the address space, which catches a wrong split between index and tag. Refill words arrive with gaps of zero to three clocks. A burst-only or slow-only buffer fails one of these runs, and a fill that starts early produces a response before the last word. Directed cases cover the following:
- a fifth word straight after the fourth, and stray words while idle, which would corrupt a line if the buffer accepted them;
- an exact count of stall cycles for an idle invalidate and for a deferred one;
- fetches held up during a sweep, which must not be accepted.

// File: rtl/icq_pkg.sv
package icq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COLLECT,
        ST_FILL,
        ST_ANSWER,
        ST_SWEEP
    } icq_state_e;

    localparam int unsigned WORD_W     = 32;
    localparam int unsigned LINE_WORDS = 4;
endpackage

// File: rtl/icq_read_buffer.sv
module icq_read_buffer
    import icq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_en,
    input  logic [WORD_W-1:0] push_word,
    input  logic              clear,
    input  logic [1:0]        rd_sel,
    output logic [WORD_W-1:0] rd_word,
    output logic [2:0]        count
);
    logic [2:0]        count_q;
    logic [WORD_W-1:0] slot_q [LINE_WORDS];
    logic              accept;

    assign accept = push_en && (count_q < 3'(LINE_WORDS));

    always_ff @(posedge clk) begin
        if (!rst_n)
            count_q <= '0;
        else if (clear)
            count_q <= '0;
        else if (accept)
            count_q <= count_q + 3'd1;
    end

    for (genvar s = 0; s < LINE_WORDS; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (accept && count_q[1:0] == 2'(s))
                slot_q[s] <= push_word;
        end
    end

    assign rd_word = slot_q[rd_sel];
    assign count   = count_q;

    // R4: once four words are held, further strobes leave the fill level alone
    p_full_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == 3'(LINE_WORDS) && !clear) |=> (count_q == 3'(LINE_WORDS)));
endmodule

// File: rtl/icq_tag_store.sv
module icq_tag_store #(
    parameter int unsigned NUM_LINES = 256,
    parameter int unsigned IDX_W     = 8,
    parameter int unsigned TAG_W     = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] look_idx,
    input  logic [TAG_W-1:0] look_tag,
    output logic             hit,
    input  logic             commit,
    input  logic [IDX_W-1:0] commit_idx,
    input  logic [TAG_W-1:0] commit_tag,
    input  logic             sweep_en,
    input  logic [IDX_W-1:0] sweep_idx
);
    logic [NUM_LINES-1:0] valid_q;
    logic [TAG_W-1:0]     tag_q [NUM_LINES];

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        always_ff @(posedge clk) begin
            if (!rst_n)
                valid_q[l] <= 1'b0;
            else if (sweep_en && sweep_idx == IDX_W'(l))
                valid_q[l] <= 1'b0;
            else if (commit && commit_idx == IDX_W'(l))
                valid_q[l] <= 1'b1;
        end

        always_ff @(posedge clk) begin
            if (commit && commit_idx == IDX_W'(l))
                tag_q[l] <= commit_tag;
        end
    end

    assign hit = valid_q[look_idx] && (tag_q[look_idx] == look_tag);

    // R8: the line visited by the sweep is invalid one cycle later
    p_sweep_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sweep_en |=> !valid_q[$past(sweep_idx)]);
endmodule

// File: rtl/icq_data_store.sv
module icq_data_store
    import icq_pkg::*;
#(
    parameter int unsigned IDX_W = 8
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [1:0]        rd_off,
    output logic [WORD_W-1:0] rd_word,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [1:0]        wr_off,
    input  logic [WORD_W-1:0] wr_word
);
    localparam int unsigned DEPTH = (1 << IDX_W) * LINE_WORDS;

    logic [WORD_W-1:0] word_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en)
            word_q[{wr_idx, wr_off}] <= wr_word;
    end

    assign rd_word = word_q[{rd_idx, rd_off}];
endmodule

// File: rtl/icq_ctrl.sv
module icq_ctrl
    import icq_pkg::*;
#(
    parameter int unsigned NUM_LINES = 256,
    parameter int unsigned IDX_W     = 8,
    parameter int unsigned TAG_W     = 20
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   fetch_req,
    input  logic [TAG_W-1:0]       req_tag,
    input  logic [IDX_W-1:0]       req_idx,
    input  logic [1:0]             req_off,
    input  logic                   inv_all,
    input  logic                   lookup_hit,
    input  logic [WORD_W-1:0]      hit_word,
    input  logic [2:0]             buf_count,
    input  logic [WORD_W-1:0]      buf_word,
    output logic                   fetch_ready,
    output logic                   rsp_valid,
    output logic [WORD_W-1:0]      rsp_data,
    output logic                   mem_rd_req,
    output logic [TAG_W+IDX_W-1:0] mem_rd_line,
    output logic                   collect_en,
    output logic                   buf_clear,
    output logic [1:0]             buf_sel,
    output logic                   fill_en,
    output logic [IDX_W-1:0]       fill_idx,
    output logic [TAG_W-1:0]       fill_tag,
    output logic                   commit,
    output logic                   sweep_en,
    output logic [IDX_W-1:0]       sweep_idx
);
    icq_state_e        state_q, state_d;
    logic [TAG_W-1:0]  miss_tag_q;
    logic [IDX_W-1:0]  miss_idx_q;
    logic [1:0]        miss_off_q;
    logic [1:0]        fill_cnt_q;
    logic [IDX_W-1:0]  sweep_cnt_q;
    logic              inv_pend_q;
    logic              rsp_valid_q;
    logic [WORD_W-1:0] rsp_data_q;
    logic              rd_req_q;
    logic              accept;

    assign fetch_ready = (state_q == ST_IDLE) && !inv_all && !inv_pend_q;
    assign accept      = fetch_req && fetch_ready;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (inv_all || inv_pend_q)
                    state_d = ST_SWEEP;
                else if (accept && !lookup_hit)
                    state_d = ST_COLLECT;
            end
            ST_COLLECT: if (buf_count == 3'(LINE_WORDS)) state_d = ST_FILL;
            ST_FILL:    if (fill_cnt_q == 2'd3)          state_d = ST_ANSWER;
            ST_ANSWER:  state_d = ST_IDLE;
            ST_SWEEP:   if (sweep_cnt_q == IDX_W'(NUM_LINES - 1)) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        collect_en = (state_q == ST_COLLECT);
        fill_en    = (state_q == ST_FILL);
        commit     = (state_q == ST_FILL) && (fill_cnt_q == 2'd3);
        buf_clear  = (state_q == ST_ANSWER);
        buf_sel    = (state_q == ST_ANSWER) ? miss_off_q : fill_cnt_q;
        sweep_en   = (state_q == ST_SWEEP);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rsp_data_q  <= '0;
            rd_req_q    <= 1'b0;
            miss_tag_q  <= '0;
            miss_idx_q  <= '0;
            miss_off_q  <= '0;
            fill_cnt_q  <= '0;
            sweep_cnt_q <= '0;
            inv_pend_q  <= 1'b0;
        end else begin
            rsp_valid_q <= 1'b0;
            rd_req_q    <= 1'b0;
            if (state_q == ST_IDLE && accept) begin
                miss_tag_q <= req_tag;
                miss_idx_q <= req_idx;
                miss_off_q <= req_off;
                if (lookup_hit) begin
                    rsp_valid_q <= 1'b1;
                    rsp_data_q  <= hit_word;
                end else begin
                    rd_req_q <= 1'b1;
                end
            end
            if (state_q == ST_ANSWER) begin
                rsp_valid_q <= 1'b1;
                rsp_data_q  <= buf_word;
            end
            fill_cnt_q  <= (state_q == ST_FILL)  ? fill_cnt_q + 2'd1 : 2'd0;
            sweep_cnt_q <= (state_q == ST_SWEEP) ? sweep_cnt_q + IDX_W'(1) : '0;
            if (state_q == ST_IDLE)
                inv_pend_q <= 1'b0;
            else if (inv_all && state_q != ST_SWEEP)
                inv_pend_q <= 1'b1;
        end
    end

    assign rsp_valid   = rsp_valid_q;
    assign rsp_data    = rsp_data_q;
    assign mem_rd_req  = rd_req_q;
    assign mem_rd_line = {miss_tag_q, miss_idx_q};
    assign fill_idx    = miss_idx_q;
    assign fill_tag    = miss_tag_q;
    assign sweep_idx   = sweep_cnt_q;

    // R2: a hit is answered on the next clock with the word looked up
    p_hit_answer_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && lookup_hit) |=> (rsp_valid && rsp_data == $past(hit_word)));
    // R3: a miss issues its read on the next clock
    p_miss_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !lookup_hit) |=> mem_rd_req);
    // R3: the read request lasts one cycle
    p_read_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |=> !mem_rd_req);
    // R5: the fill only runs with four words staged
    p_fill_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |-> (buf_count == 3'(LINE_WORDS)));
    // R6: the refill answer always follows the last fill cycle
    p_answer_after_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ANSWER) |-> ($past(state_q) == ST_FILL));
    // R9: a deferred invalidate starts its sweep as soon as idle is reached
    p_deferred_sweep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && inv_pend_q) |=> (state_q == ST_SWEEP));
endmodule

// File: rtl/icache_qw.sv
module icache_qw #(
    parameter int unsigned CACHE_BYTES = 4096,
    parameter int unsigned ADDR_W      = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_req,
    input  logic [ADDR_W-3:0] fetch_waddr,
    output logic              fetch_ready,
    output logic              rsp_valid,
    output logic [31:0]       rsp_data,
    input  logic              inv_all,
    output logic              mem_rd_req,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_word_valid,
    input  logic [31:0]       mem_word_data
);
    localparam int unsigned NUM_LINES = CACHE_BYTES / 16;
    localparam int unsigned IDX_W     = $clog2(NUM_LINES);
    localparam int unsigned TAG_W     = ADDR_W - 4 - IDX_W;
    localparam int unsigned WA_W      = ADDR_W - 2;

    logic [TAG_W-1:0]       req_tag;
    logic [IDX_W-1:0]       req_idx;
    logic [1:0]             req_off;
    logic                   lookup_hit;
    logic [31:0]            hit_word;
    logic [2:0]             buf_count;
    logic [31:0]            buf_word;
    logic                   collect_en, buf_clear, fill_en, commit, sweep_en;
    logic [1:0]             buf_sel;
    logic [IDX_W-1:0]       fill_idx, sweep_idx;
    logic [TAG_W-1:0]       fill_tag;
    logic [TAG_W+IDX_W-1:0] rd_line;

    assign req_off     = fetch_waddr[1:0];
    assign req_idx     = fetch_waddr[IDX_W+1:2];
    assign req_tag     = fetch_waddr[WA_W-1:IDX_W+2];
    assign mem_rd_addr = {rd_line, 4'b0000};

    icq_ctrl #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req),
        .req_tag(req_tag), .req_idx(req_idx), .req_off(req_off),
        .inv_all(inv_all), .lookup_hit(lookup_hit), .hit_word(hit_word),
        .buf_count(buf_count), .buf_word(buf_word),
        .fetch_ready(fetch_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .mem_rd_req(mem_rd_req), .mem_rd_line(rd_line),
        .collect_en(collect_en), .buf_clear(buf_clear), .buf_sel(buf_sel),
        .fill_en(fill_en), .fill_idx(fill_idx), .fill_tag(fill_tag),
        .commit(commit), .sweep_en(sweep_en), .sweep_idx(sweep_idx)
    );

    icq_read_buffer u_rbuf (
        .clk(clk), .rst_n(rst_n),
        .push_en(collect_en && mem_word_valid), .push_word(mem_word_data),
        .clear(buf_clear), .rd_sel(buf_sel), .rd_word(buf_word),
        .count(buf_count)
    );

    icq_tag_store #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst_n(rst_n),
        .look_idx(req_idx), .look_tag(req_tag), .hit(lookup_hit),
        .commit(commit), .commit_idx(fill_idx), .commit_tag(fill_tag),
        .sweep_en(sweep_en), .sweep_idx(sweep_idx)
    );

    icq_data_store #(.IDX_W(IDX_W)) u_data (
        .clk(clk),
        .rd_idx(req_idx), .rd_off(req_off), .rd_word(hit_word),
        .wr_en(fill_en), .wr_idx(fill_idx), .wr_off(buf_sel), .wr_word(buf_word)
    );

    // R5: no fetch is taken while a line is being collected or filled
    p_stall_refill_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (collect_en || fill_en) |-> !fetch_ready);
endmodule

// File: tb/tb_icache_qw.sv
module tb_icache_qw;
    localparam int NLINES = 4096 / 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_req = 1'b0;
    logic [29:0] fetch_waddr = '0;
    logic        fetch_ready, rsp_valid, mem_rd_req;
    logic [31:0] rsp_data, mem_rd_addr;
    logic        inv_all = 1'b0;
    logic        mem_word_valid = 1'b0;
    logic [31:0] mem_word_data = '0;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    icache_qw dut (
        .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_waddr(fetch_waddr),
        .fetch_ready(fetch_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .inv_all(inv_all), .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_word_valid(mem_word_valid), .mem_word_data(mem_word_data)
    );

    function automatic logic [31:0] memval(input logic [31:0] a);
        return a ^ 32'h5A5A_A5A5;
    endfunction

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // {byte address, gap between refill words, expected hit}
    localparam logic [36:0] VEC [12] = '{
        {32'h0000_1000, 4'd0, 1'b0},
        {32'h0000_100C, 4'd0, 1'b1},
        {32'h0000_1004, 4'd0, 1'b1},
        {32'h0000_2008, 4'd2, 1'b0},
        {32'h0000_1008, 4'd3, 1'b0},
        {32'h0000_2344, 4'd1, 1'b0},
        {32'h0000_2348, 4'd0, 1'b1},
        {32'h0000_1000, 4'd0, 1'b1},
        {32'hFFFF_FFFC, 4'd0, 1'b0},
        {32'hFFFF_FFF0, 4'd0, 1'b1},
        {32'h0000_2340, 4'd0, 1'b1},
        {32'h0000_2000, 4'd0, 1'b0}
    };

    task automatic do_fetch(input logic [31:0] a, input int gap, input bit exp_hit,
                            input int inv_at, input bit extra);
        bit early, ready_seen, extra_req, got;
        int k;
        @(negedge clk);
        k = 0;
        while (!fetch_ready && k < 1000) begin @(negedge clk); k++; end
        fetch_req   = 1'b1;
        fetch_waddr = a[31:2];
        @(negedge clk);
        fetch_req = 1'b0;
        chk(rsp_valid == exp_hit, "R7 hit/miss outcome", 32'(rsp_valid), 32'(exp_hit));
        if (rsp_valid) begin
            chk(rsp_data == memval(a), "R2 hit data", rsp_data, memval(a));
            chk(!mem_rd_req, "R2 no read on hit", 32'(mem_rd_req), 0);
        end else begin
            chk(mem_rd_req, "R3 read issued", 32'(mem_rd_req), 1);
            chk(mem_rd_addr == {a[31:4], 4'h0}, "R3 line address", mem_rd_addr, {a[31:4], 4'h0});
            early = 0; ready_seen = 0; extra_req = 0;
            for (int w = 0; w < 4; w++) begin
                for (int g = 0; g < gap; g++) begin
                    @(negedge clk);
                    if (rsp_valid) early = 1;
                    if (fetch_ready) ready_seen = 1;
                    if (mem_rd_req) extra_req = 1;
                end
                mem_word_valid = 1'b1;
                mem_word_data  = memval({a[31:4], 4'(w * 4)});
                if (inv_at == w) inv_all = 1'b1;
                @(negedge clk);
                mem_word_valid = 1'b0;
                inv_all = 1'b0;
                if (w < 3 && rsp_valid) early = 1;
                if (fetch_ready) ready_seen = 1;
                if (mem_rd_req) extra_req = 1;
            end
            if (extra) begin
                mem_word_valid = 1'b1;
                mem_word_data  = 32'hDEAD_BEEF;
                @(negedge clk);
                mem_word_valid = 1'b0;
            end
            chk(!extra_req, "R3 single read pulse", 32'(extra_req), 0);
            chk(!early, "R5 no answer before fourth word", 32'(early), 0);
            got = rsp_valid;
            k = 0;
            while (!got && k < 20) begin
                if (fetch_ready) ready_seen = 1;
                @(negedge clk);
                got = rsp_valid;
                k++;
            end
            chk(!ready_seen, "R5 stall during refill", 32'(ready_seen), 0);
            chk(got, "R6 refill answer", 32'(got), 1);
            chk(rsp_data == memval(a), "R6 critical word", rsp_data, memval(a));
        end
    endtask

    task automatic count_stall(output int n);
        n = 0;
        while (!fetch_ready && n < 2 * NLINES) begin @(negedge clk); n++; end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int n;
        bit taken;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(fetch_ready, "R1 ready after reset", 32'(fetch_ready), 1);
        chk(!rsp_valid, "R1 no response after reset", 32'(rsp_valid), 0);
        chk(!mem_rd_req, "R1 no read after reset", 32'(mem_rd_req), 0);

        // R2 R3 R5 R6 R7 vector walk
        foreach (VEC[i])
            do_fetch(VEC[i][36:5], int'(VEC[i][4:1]), VEC[i][0], -1, 1'b0);

        // R4: fifth word right after the fourth, then stray words while idle
        do_fetch(32'h0000_0450, 0, 1'b0, -1, 1'b1);
        mem_word_valid = 1'b1; mem_word_data = 32'hBAD0_0001;
        repeat (2) @(negedge clk);
        mem_word_valid = 1'b0;
        for (int o = 0; o < 4; o++)
            do_fetch(32'h0000_0450 + 32'(o * 4), 0, 1'b1, -1, 1'b0);

        // R8: idle invalidate-all, fetch held off, then everything misses
        @(negedge clk);
        inv_all = 1'b1; fetch_req = 1'b1; fetch_waddr = 30'h0000_0115;
        @(negedge clk);
        inv_all = 1'b0;
        taken = 0;
        n = 0;
        while (!fetch_ready && n < 2 * NLINES) begin
            if (rsp_valid || mem_rd_req) taken = 1;
            @(negedge clk); n++;
        end
        fetch_req = 1'b0;
        chk(n == NLINES, "R8 sweep length", 32'(n), 32'(NLINES));
        chk(!taken, "R8 no fetch taken during sweep", 32'(taken), 0);
        @(negedge clk);
        chk(!rsp_valid && !mem_rd_req, "R8 held fetch not taken", 32'(rsp_valid), 0);
        do_fetch(32'h0000_2348, 0, 1'b0, -1, 1'b0);
        do_fetch(32'hFFFF_FFF4, 0, 1'b0, -1, 1'b0);

        // R9: invalidate during a refill is deferred
        do_fetch(32'h0000_0808, 1, 1'b0, 1, 1'b0);
        count_stall(n);
        chk(n == NLINES + 1, "R9 deferred sweep length", 32'(n), 32'(NLINES + 1));
        do_fetch(32'h0000_0808, 0, 1'b0, -1, 1'b0);
        do_fetch(32'h0000_080C, 0, 1'b1, -1, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule